// File: doc/BRIEF.md
# Modulo Timer Counter with Overflow Flag

This block is a 16-bit up-counter that advances on qualified timer ticks and wraps back to zero at a programmable limit. When the count sits at the limit and a tick arrives, the count returns to zero and a sticky overflow flag is raised. Software can turn that flag into an interrupt request, and it clears the flag through a write-one control bit. The limit is held as two byte registers. Software writes them one at a time through a small byte-wide register port.

Updating a 16-bit limit over an 8-bit port takes two writes, so for a few cycles the limit holds one new byte and one old byte. To keep that half-written value from producing a false overflow, a write to the upper byte arms an inhibit. The inhibit lasts until the lower byte is written. While it is armed the counter still wraps, but the flag cannot be set. Software is expected to zero the counter, through a control bit, before it changes the limit.

Top module: `modtmr_top`

## Requirements
- R1: After synchronous reset the count is 0, the flag and the interrupt request are low, both limit bytes read 0xFF (limit 0xFFFF), and interrupt enable and halt are 0.
- R2: The count changes only on a clock edge where `tick` is 1 and halt (control bit 1) is 0. With halt set or `tick` low, the count holds.
- R3: On a qualified tick while the count equals the limit, the count becomes 0 and the flag becomes 1 at that same edge, unless R6 inhibits the flag.
- R4: The flag stays set until software writes 1 to control bit 3. If that write lands on the same edge as a new overflow, the flag stays set.
- R5: `ovf_irq` is high exactly when the flag is set and interrupt enable (control bit 0) is 1.
- R6: Writing the limit high byte (address 0) inhibits flag setting until the limit low byte (address 1) is written. During the inhibit the counter still wraps at the limit.
- R7: Reading address 0 or 1 returns the last byte written there, including a high byte whose low-byte write has not happened yet.
- R8: Writing 1 to control bit 2 sets the count to 0 at that edge. This clear takes priority over a tick, and no overflow is produced on that edge.
- R9: If the count is above the limit, it keeps counting to 0xFFFF and rolls over to 0 without setting the flag.
- R10: Address 2 is control. On write, bit 0 is interrupt enable, bit 1 is halt, and bits 2 and 3 are one-shot strobes. On read, bit 0 is enable, bit 1 is halt, bit 7 is the flag, and all other bits are 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable; one count step per asserted cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a flag clear that lands on the exact edge of an overflow. The bench zeroes the counter, issues exactly as many ticks as the limit value, and then puts the clear strobe and the wrapping tick on the same edge. The second is a count that already sits above a newly written limit. The bench runs the counter past 0x30 under a larger limit, then lowers the limit to 0x10 and lets the count climb all the way to 0xFFFF and roll over. A reference model in the bench follows every cycle of both runs.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;

    localparam int BYTE_W_DEF = 8;
    localparam int ADDR_W_DEF = 2;

    typedef enum logic [1:0] {
        SEL_LIM_HI = 2'd0,
        SEL_LIM_LO = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTL_IRQ_EN   = 0;
    localparam int CTL_HALT     = 1;
    localparam int CTL_CNT_CLR  = 2;
    localparam int CTL_FLAG_CLR = 3;
    localparam int STS_FLAG     = 7;

    typedef struct packed {
        logic lim_hi_we;
        logic lim_lo_we;
        logic ctrl_we;
    } wr_dec_t;

    typedef struct packed {
        logic irq_en;
        logic halt;
    } ctrl_t;

    function automatic wr_dec_t decode_write(input logic we, input logic [1:0] sel);
        wr_dec_t d;
        d.lim_hi_we = we && (reg_sel_e'(sel) == SEL_LIM_HI);
        d.lim_lo_we = we && (reg_sel_e'(sel) == SEL_LIM_LO);
        d.ctrl_we   = we && (reg_sel_e'(sel) == SEL_CTRL);
        return d;
    endfunction

endpackage

// File: rtl/modtmr_limit_regs.sv
module modtmr_limit_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lim_hi,
    output logic [BYTE_W-1:0] lim_lo,
    output logic              hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lim_hi <= '1;
            lim_lo <= '1;
            hold   <= 1'b0;
        end else begin
            if (hi_we) begin
                lim_hi <= wdata;
                hold   <= 1'b1;
            end
            if (lo_we) begin
                lim_lo <= wdata;
                hold   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/modtmr_counter.sv
module modtmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic step;
    logic at_limit;

    assign step     = tick && !halt && !clr;
    assign at_limit = (count == limit);
    assign wrap     = step && at_limit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (step) begin
            if (at_limit) count <= '0;
            else          count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import modtmr_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [2*BYTE_W-1:0] count,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    localparam int CNT_W = 2 * BYTE_W;

    wr_dec_t           dec;
    ctrl_t             ctrl_q;
    logic              halt_w;
    logic              irq_en_w;
    logic              cnt_clr;
    logic              flag_clr;
    logic [BYTE_W-1:0] lim_hi;
    logic [BYTE_W-1:0] lim_lo;
    logic              lim_hold;
    logic [CNT_W-1:0]  limit_val;
    logic              wrap;

    assign dec      = decode_write(bus_we, bus_addr[1:0]);
    assign cnt_clr  = dec.ctrl_we && bus_wdata[CTL_CNT_CLR];
    assign flag_clr = dec.ctrl_we && bus_wdata[CTL_FLAG_CLR];
    assign halt_w   = ctrl_q.halt;
    assign irq_en_w = ctrl_q.irq_en;
    assign limit_val = {lim_hi, lim_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (dec.ctrl_we) begin
            ctrl_q.irq_en <= bus_wdata[CTL_IRQ_EN];
            ctrl_q.halt   <= bus_wdata[CTL_HALT];
        end
    end

    modtmr_limit_regs #(.BYTE_W(BYTE_W)) u_limit (
        .clk    (clk),
        .rst    (rst),
        .hi_we  (dec.lim_hi_we),
        .lo_we  (dec.lim_lo_we),
        .wdata  (bus_wdata),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .hold   (lim_hold)
    );

    modtmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .halt  (halt_w),
        .clr   (cnt_clr),
        .limit (limit_val),
        .count (count),
        .wrap  (wrap)
    );

    modtmr_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (wrap && !lim_hold),
        .clr_req (flag_clr),
        .flag    (ovf_flag)
    );

    assign ovf_irq = ovf_flag && irq_en_w;

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr[1:0]))
            SEL_LIM_HI: bus_rdata = lim_hi;
            SEL_LIM_LO: bus_rdata = lim_lo;
            SEL_CTRL: begin
                bus_rdata[CTL_IRQ_EN] = irq_en_w;
                bus_rdata[CTL_HALT]   = halt_w;
                bus_rdata[STS_FLAG]   = ovf_flag;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/modtmr_checker.sv
module modtmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             halt,
    input logic             cnt_clr,
    input logic             flag_clr,
    input logic             hold,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] count,
    input logic             flag,
    input logic             irq
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (count == '0) && !flag && !irq);

    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (halt && !cnt_clr) |=> $stable(count));

    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !cnt_clr && count == limit) |=> (count == '0));

    assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !cnt_clr && count == limit && !hold) |=> flag);

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    assert_hold_blocks_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && !flag) |=> !flag);

    assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (count == '0));
endmodule

bind modtmr_top modtmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .halt     (halt_w),
    .cnt_clr  (cnt_clr),
    .flag_clr (flag_clr),
    .hold     (lim_hold),
    .limit    (limit_val),
    .count    (count),
    .flag     (ovf_flag),
    .irq      (ovf_irq)
);

// File: tb/test_modtmr_top.sv
`timescale 1ns/100ps
module test_modtmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [15:0] count;
    logic        ovf_flag;
    logic        ovf_irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    modtmr_top i_modtmr_top (
        .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    // behavioural reference state
    int m_hi = 255, m_lo = 255, m_cnt = 0;
    bit m_hold = 0, m_flag = 0, m_en = 0, m_halt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_hi = 255; m_lo = 255; m_cnt = 0;
            m_hold = 0; m_flag = 0; m_en = 0; m_halt = 0;
        end else begin
            int  lim;
            bit  clr, fclr, wrapped;
            lim     = m_hi * 256 + m_lo;
            clr     = bus_we && bus_addr == 2 && bus_wdata[2];
            fclr    = bus_we && bus_addr == 2 && bus_wdata[3];
            wrapped = 0;
            if (clr) m_cnt = 0;
            else if (tick && !m_halt) begin
                if (m_cnt == lim) begin m_cnt = 0; wrapped = 1; end
                else m_cnt = (m_cnt + 1) % 65536;
            end
            if (wrapped && !m_hold) m_flag = 1;
            else if (fclr) m_flag = 0;
            if (bus_we && bus_addr == 0) begin m_hi = bus_wdata; m_hold = 1; end
            if (bus_we && bus_addr == 1) begin m_lo = bus_wdata; m_hold = 0; end
            if (bus_we && bus_addr == 2) begin m_en = bus_wdata[0]; m_halt = bus_wdata[1]; end
        end
    end

    function automatic int model_rd(input int a);
        case (a)
            0: return m_hi;
            1: return m_lo;
            2: return (m_flag ? 128 : 0) + (m_halt ? 2 : 0) + (m_en ? 1 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(count == m_cnt[15:0], "R2 count vs model", count, m_cnt);
            chk(ovf_flag == m_flag, "R3 flag vs model", ovf_flag, m_flag);
            chk(ovf_irq == (m_flag && m_en), "R5 irq vs model", ovf_irq, m_flag && m_en);
            chk(bus_rdata == model_rd(bus_addr), "R7 rdata vs model", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic step(input bit t);
        tick = t;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic wr(input int a, input int d, input bit t = 1'b0);
        bus_we = 1'b1; bus_addr = a[1:0]; bus_wdata = d[7:0]; tick = t;
        @(posedge clk); #1;
        bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        bus_addr = a[1:0];
        #0.5;
        chk(bus_rdata == exp[7:0], req, bus_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(count == 0, "R1 count", count, 0);
        chk(ovf_flag == 0 && ovf_irq == 0, "R1 flag/irq", {ovf_flag, ovf_irq}, 0);
        rd(0, 8'hFF, "R1 limit high");
        rd(1, 8'hFF, "R1 limit low");
        rd(2, 0, "R1 control");

        // limit 5, wrap and flag
        wr(0, 0); wr(1, 5); wr(2, 8'h04);
        for (int i = 0; i < 5; i++) step(1);
        chk(count == 5, "R2 count at limit", count, 5);
        step(1);
        chk(count == 0, "R3 wrap to zero", count, 0);
        chk(ovf_flag == 1, "R3 flag set", ovf_flag, 1);
        chk(ovf_irq == 0, "R5 irq masked", ovf_irq, 0);
        wr(2, 8'h01);
        chk(ovf_irq == 1, "R5 irq enabled", ovf_irq, 1);
        step(0); step(0);
        chk(ovf_flag == 1, "R4 flag sticky", ovf_flag, 1);
        wr(2, 8'h09);
        chk(ovf_flag == 0, "R4 flag cleared", ovf_flag, 0);

        // R4 clear on the overflow edge
        wr(2, 8'h05);
        for (int i = 0; i < 5; i++) step(1);
        wr(2, 8'h09, 1'b1);
        chk(ovf_flag == 1, "R4 overflow beats clear", ovf_flag, 1);
        chk(count == 0, "R3 wrap with clear strobe", count, 0);

        // R2 halt
        wr(2, 8'h03);
        for (int i = 0; i < 3; i++) step(1);
        chk(count == 0, "R2 halted", count, 0);
        rd(2, 8'h83, "R10 control readback");
        wr(2, 8'h01);
        for (int i = 0; i < 30; i++) step(i % 3 == 0);
        chk(count == 4, "R2 gated by tick", count, 4);

        // R6 inhibit
        wr(2, 8'h0D);
        wr(0, 0);
        for (int i = 0; i < 20; i++) step(1);
        chk(ovf_flag == 0, "R6 flag inhibited", ovf_flag, 0);
        wr(0, 8'h12);
        rd(0, 8'h12, "R7 pending high byte");
        rd(1, 8'h05, "R7 low byte");
        wr(0, 0); wr(1, 3);
        for (int i = 0; i < 10; i++) step(1);
        chk(ovf_flag == 1, "R6 inhibit released", ovf_flag, 1);

        // R8 clear beats tick
        for (int i = 0; i < 2; i++) step(1);
        wr(2, 8'h05, 1'b1);
        chk(count == 0, "R8 clear priority", count, 0);
        rd(2, 8'h81, "R10 flag bit 7 and enable");
        rd(3, 0, "R10 unused address");

        // R9 count above limit
        wr(1, 8'h40); wr(2, 8'h0D);
        for (int i = 0; i < 8'h30; i++) step(1);
        wr(1, 8'h10);
        chk(count == 16'h30, "R9 above limit", count, 16'h30);
        for (int i = 0; i < 70000 && count != 0; i++) step(1);
        chk(count == 0, "R9 rolled over", count, 0);
        chk(ovf_flag == 0, "R9 no flag on rollover", ovf_flag, 0);
        for (int i = 0; i < 17; i++) step(1);
        chk(ovf_flag == 1, "R3 wrap at new limit", ovf_flag, 1);

        step(0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule